// File: doc/BRIEF.md
# Serial In-System Memory Programming Port

This block is the serial programming front end of a small microcontroller. An external programmer pulls the active-low `prog_rst_n` input low, then drives a serial clock and data line and reads the reply line. The block samples all three with the internal system clock. It assembles four-byte instructions and turns them into erase, write and read operations on two behavioural arrays: a program flash and a data EEPROM. It returns read data serially on `miso`.

Every instruction has four bytes, sent most significant bit first. Byte 1 is the opcode. Bytes 2 and 3 form a 16-bit address, with byte 2 as the high half. Byte 4 carries the write data, and during a read it is the slot in which the data is returned. Nothing is accepted until an enable instruction has been taken. After each erase or write, a self-timed busy window rejects any new instruction.

The control state machine has four states. OFF is held while `prog_rst_n` is high. OFF moves to LOCKED on the first cycle with `prog_rst_n` low. LOCKED moves to READY when an enable instruction completes. READY moves to BUSY when an erase or write completes. BUSY returns to READY after `BUSY_CYCLES` cycles. Any state returns to OFF when `prog_rst_n` goes high.

Top module: `isp_serial_programmer`

## Requirements
- R1: The block acts only while `prog_rst_n` is low. While it is high, `miso` is 0, the bit count is cleared and the enabled state is lost. A partly shifted instruction is therefore dropped, and the next instruction starts at its first bit. Array contents are kept.
- R2: After `prog_rst_n` falls, no erase, write or read has any effect until an enable instruction (opcode 0xA5) has completed. A read issued before that returns 0x00 in byte 4.
- R3: `sck` and `mosi` pass through a two-flop synchroniser. `mosi` is taken on each rising edge of the synchronised `sck`. Operation is correct with low and high phases of 3 system cycles each, and also of 4 system cycles each.
- R4: An instruction is exactly 32 bits, sent MSB first, in the order opcode, address high, address low, data.
- R5: Opcode 0xC3 (chip erase) sets every byte of both arrays to 0xFF.
- R6: Opcode 0x4E (EEPROM write) replaces the addressed byte with the data byte directly. No erase is needed first.
- R7: Opcode 0x4C (flash write) can only clear bits: the new content is the old content AND the data byte.
- R8: Opcodes 0x2C (flash read) and 0x2E (EEPROM read) return the addressed byte on `miso` during byte 4, MSB first.
- R9: `miso` changes only after a falling edge of `sck` is detected. It holds steady for the whole high phase of `sck`.
- R10: During byte 3 of an enable instruction, `miso` returns a copy of byte 2.
- R11: Every erase or write starts a busy window of `BUSY_CYCLES` system cycles. An instruction whose first rising `sck` edge falls inside this window is ignored entirely. If that instruction is a read, it returns 0x00.
- R12: An opcode other than the six listed has no effect on either array and does not start a busy window.
- R13: An address at or above an array's depth is ignored by writes to that array. A read from such an address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial lines |
| prog_rst_n | input | 1 | Active-low programming-mode request; high resets the control logic |
| sck | input | 1 | Serial clock from the programmer, asynchronous |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial reply data to the programmer |

## Verification
A wrong bit count or a wrong captured address shows up on `miso` as a shifted or misplaced byte. This becomes visible in the first read or enable echo after the fault, within one instruction time. A wrong lock or busy state either produces data where 0x00 is expected, or causes a write that a later read exposes, typically two instructions later. A wrong array update, such as overwrite where AND is required or a missing erase, appears only at the next read of that address. The bench therefore reads back every location it writes.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam logic [7:0] OP_ENABLE = 8'hA5;
    localparam logic [7:0] OP_ERASE  = 8'hC3;
    localparam logic [7:0] OP_PWRITE = 8'h4C;
    localparam logic [7:0] OP_PREAD  = 8'h2C;
    localparam logic [7:0] OP_EWRITE = 8'h4E;
    localparam logic [7:0] OP_EREAD  = 8'h2E;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_LOCKED,
        ST_READY,
        ST_BUSY
    } isp_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ENABLE,
        CMD_ERASE,
        CMD_PWRITE,
        CMD_PREAD,
        CMD_EWRITE,
        CMD_EREAD
    } isp_cmd_e;

    function automatic isp_cmd_e decode_op(input logic [7:0] op);
        isp_cmd_e c;
        case (op)
            OP_ENABLE: c = CMD_ENABLE;
            OP_ERASE:  c = CMD_ERASE;
            OP_PWRITE: c = CMD_PWRITE;
            OP_PREAD:  c = CMD_PREAD;
            OP_EWRITE: c = CMD_EWRITE;
            OP_EREAD:  c = CMD_EREAD;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic sck,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);

    // sck_pipe[STAGES] is the delayed copy used for edge detection
    logic [STAGES:0]   sck_pipe;
    logic [STAGES-1:0] mosi_pipe;

    always_ff @(posedge clk) begin
        if (clr) begin
            sck_pipe  <= '0;
            mosi_pipe <= '0;
        end else begin
            sck_pipe  <= {sck_pipe[STAGES-1:0], sck};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
        end
    end

    assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
    assign sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
    assign mosi_s   = mosi_pipe[STAGES-1];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (clr)
        sck_rise |=> !sck_rise); // R3

endmodule

// File: rtl/isp_frame.sv
module isp_frame (
    input  logic       clk,
    input  logic       clr,
    input  logic       rise,
    input  logic       mosi_s,
    output logic       first_bit,
    output logic       byte_done,
    output logic [1:0] byte_num,
    output logic [7:0] byte_val,
    output logic [7:0] op_q,
    output logic [7:0] ahi_q,
    output logic [7:0] alo_q
);

    logic [4:0] cnt_q;
    logic [6:0] sh_q;

    assign byte_val  = {sh_q, mosi_s};
    assign byte_num  = cnt_q[4:3];
    assign byte_done = rise && (cnt_q[2:0] == 3'd7);
    assign first_bit = rise && (cnt_q == 5'd0);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
            op_q  <= '0;
            ahi_q <= '0;
            alo_q <= '0;
        end else if (rise) begin
            cnt_q <= cnt_q + 5'd1;
            sh_q  <= byte_val[6:0];
            if (byte_done) begin
                unique case (byte_num)
                    2'd0: op_q  <= byte_val;
                    2'd1: ahi_q <= byte_val;
                    2'd2: alo_q <= byte_val;
                    2'd3: ;
                endcase
            end
        end
    end

    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (clr)
        byte_done |=> (cnt_q[2:0] == 3'd0)); // R4

endmodule

// File: rtl/isp_miso_tx.sv
module isp_miso_tx (
    input  logic       clk,
    input  logic       clr,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       fall,
    output logic       miso
);

    logic [7:0] buf_q;
    logic       miso_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            buf_q  <= '0;
            miso_q <= 1'b0;
        end else begin
            if (load) begin
                buf_q <= load_val;
            end else if (fall) begin
                buf_q <= {buf_q[6:0], 1'b0};
            end
            if (fall) begin
                miso_q <= buf_q[7];
            end
        end
    end

    assign miso = miso_q;

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (clr)
        !fall |=> $stable(miso_q)); // R9

endmodule

// File: rtl/isp_mem_arrays.sv
module isp_mem_arrays #(
    parameter int PROG_AW = 9,
    parameter int EE_AW   = 6
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        erase,
    input  logic        pwe,
    input  logic        ewe,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  prdata,
    output logic [7:0]  erdata
);

    localparam int PDEPTH = 1 << PROG_AW;
    localparam int EDEPTH = 1 << EE_AW;

    logic [7:0] pmem [PDEPTH];
    logic [7:0] emem [EDEPTH];

    logic [PROG_AW-1:0] pidx;
    logic [EE_AW-1:0]   eidx;
    logic               p_in, e_in;
    logic               pwe_ok, ewe_ok;

    assign pidx   = addr[PROG_AW-1:0];
    assign eidx   = addr[EE_AW-1:0];
    assign p_in   = (addr >> PROG_AW) == 16'd0;
    assign e_in   = (addr >> EE_AW) == 16'd0;
    assign pwe_ok = pwe && p_in;
    assign ewe_ok = ewe && e_in;

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < PDEPTH; i++) pmem[i] <= 8'hFF;
        end else if (pwe_ok) begin
            pmem[pidx] <= pmem[pidx] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < EDEPTH; i++) emem[i] <= 8'hFF;
        end else if (ewe_ok) begin
            emem[eidx] <= wdata;
        end
    end

    assign prdata = p_in ? pmem[pidx] : 8'hFF;
    assign erdata = e_in ? emem[eidx] : 8'hFF;

    AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (clr)
        erase |=> (pmem[PDEPTH-1] == 8'hFF) && (emem[0] == 8'hFF)); // R5
    AST_EE_OVERWRITE: assert property (@(posedge clk) disable iff (clr)
        ewe_ok |=> (emem[$past(eidx)] == $past(wdata))); // R6
    AST_FLASH_AND: assert property (@(posedge clk) disable iff (clr)
        pwe_ok |=> (pmem[$past(pidx)] == $past(pmem[pidx] & wdata))); // R7

endmodule

// File: rtl/isp_serial_programmer.sv
module isp_serial_programmer
    import isp_pkg::*;
#(
    parameter int PROG_AW     = 9,
    parameter int EE_AW       = 6,
    parameter int BUSY_CYCLES = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic prog_rst_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic       clr;
    logic       sck_rise, sck_fall, mosi_s;
    logic       first_bit, byte_done;
    logic [1:0] byte_num;
    logic [7:0] byte_val, op_q, ahi_q, alo_q;
    logic [7:0] prdata, erdata;
    logic [15:0] mem_addr;

    isp_state_e state_q, state_d;
    isp_cmd_e   cmd;
    logic [BW-1:0] busy_q;
    logic       frame_ok_q;
    logic       exec;
    logic       erase, pwe, ewe;
    logic       tx_load;
    logic [7:0] tx_val;

    assign clr = prog_rst_n;

    isp_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .clr      (clr),
        .sck      (sck),
        .mosi     (mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    isp_frame u_frame (
        .clk       (clk),
        .clr       (clr),
        .rise      (sck_rise),
        .mosi_s    (mosi_s),
        .first_bit (first_bit),
        .byte_done (byte_done),
        .byte_num  (byte_num),
        .byte_val  (byte_val),
        .op_q      (op_q),
        .ahi_q     (ahi_q),
        .alo_q     (alo_q)
    );

    isp_miso_tx u_tx (
        .clk      (clk),
        .clr      (clr),
        .load     (tx_load),
        .load_val (tx_val),
        .fall     (sck_fall),
        .miso     (miso)
    );

    // reads look up at byte 3 completion, writes use the stored address
    assign mem_addr = (byte_num == 2'd2) ? {ahi_q, byte_val} : {ahi_q, alo_q};

    isp_mem_arrays #(.PROG_AW(PROG_AW), .EE_AW(EE_AW)) u_mem (
        .clk    (clk),
        .clr    (clr),
        .erase  (erase),
        .pwe    (pwe),
        .ewe    (ewe),
        .addr   (mem_addr),
        .wdata  (byte_val),
        .prdata (prdata),
        .erdata (erdata)
    );

    assign cmd  = decode_op(op_q);
    assign exec = byte_done && (byte_num == 2'd3) && frame_ok_q;

    // state register, busy timer and per-frame acceptance flag
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q    <= ST_OFF;
            busy_q     <= '0;
            frame_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BUSY) begin
                busy_q <= busy_q + 1'b1;
            end else begin
                busy_q <= '0;
            end
            if (first_bit) begin
                frame_ok_q <= (state_q != ST_BUSY);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (exec && cmd == CMD_ENABLE) state_d = ST_READY;
            end
            ST_READY: begin
                if (exec && (cmd == CMD_ERASE || cmd == CMD_PWRITE || cmd == CMD_EWRITE))
                    state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (busy_q == BW'(BUSY_CYCLES - 1)) state_d = ST_READY;
            end
        endcase
    end

    // strobes toward the arrays and the reply loader
    always_comb begin
        erase   = 1'b0;
        pwe     = 1'b0;
        ewe     = 1'b0;
        tx_load = byte_done;
        tx_val  = 8'h00;
        if (exec && state_q == ST_READY) begin
            erase = (cmd == CMD_ERASE);
            pwe   = (cmd == CMD_PWRITE);
            ewe   = (cmd == CMD_EWRITE);
        end
        unique case (byte_num)
            2'd1: begin
                if (cmd == CMD_ENABLE && frame_ok_q) tx_val = byte_val;
            end
            2'd2: begin
                if (frame_ok_q && state_q == ST_READY) begin
                    if (cmd == CMD_PREAD)      tx_val = prdata;
                    else if (cmd == CMD_EREAD) tx_val = erdata;
                end
            end
            default: tx_val = 8'h00;
        endcase
    end

    AST_ENTRY_LOCKED: assert property (@(posedge clk) disable iff (clr)
        (state_q == ST_OFF) |=> (state_q == ST_LOCKED)); // R1
    AST_NO_EXEC_LOCKED: assert property (@(posedge clk) disable iff (clr)
        (state_q == ST_LOCKED) |-> !(erase || pwe || ewe)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (clr)
        $onehot0({erase, pwe, ewe})); // R4
    AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (clr)
        (erase || pwe || ewe) |=> (state_q == ST_BUSY)); // R11
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (clr)
        (state_q == ST_BUSY) |-> (busy_q < BW'(BUSY_CYCLES))); // R11

endmodule

// File: tb/isp_serial_programmer_bench.sv
module isp_serial_programmer_bench;
    import isp_pkg::*;

    localparam int BUSY = 300;
    localparam int GAP  = BUSY + 20;

    logic clk = 1'b0;
    logic prog_rst_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    wire  miso;

    always #10 clk = ~clk;

    isp_serial_programmer #(
        .PROG_AW(9), .EE_AW(6), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)
    ) u_isp_serial_programmer (
        .clk(clk), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int    n_chk = 0;
    int    n_err = 0;
    longint cyc = 0;
    int    fm [512];
    int    em [64];
    bit    en = 1'b0;
    longint t_exec = -100000;

    always @(posedge clk) cyc <= cyc + 1;

    // R1: reply line quiet while the port is inactive, checked every clock
    always @(negedge clk) begin
        if (prog_rst_n) begin
            n_chk++;
            if (miso !== 1'b0) begin
                n_err++;
                $display("FAIL R1 miso while inactive: actual=%0b expected=0", miso);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int model_read(input logic [7:0] op, input int addr);
        if (op == OP_PREAD) return (addr < 512) ? fm[addr] : 8'hFF;
        if (op == OP_EREAD) return (addr < 64) ? em[addr] : 8'hFF;
        return 0;
    endfunction

    task automatic send_frame(input logic [7:0] b1, input logic [7:0] b2,
                              input logic [7:0] b3, input logic [7:0] b4,
                              input int ph, input string tag);
        logic [31:0] word;
        logic [31:0] rx;
        logic held;
        bit   ok;
        int   addr, bad, e3, e4;
        word = {b1, b2, b3, b4};
        rx   = '0;
        ok   = 1'b0;
        bad  = 0;
        addr = {b2, b3};
        for (int i = 0; i < 32; i++) begin
            mosi = word[31-i];
            repeat (ph) @(negedge clk);
            rx[31-i] = miso;
            held = miso;
            if (i == 0) ok = (cyc - t_exec) >= BUSY;
            sck = 1'b1;
            repeat (ph) begin
                @(negedge clk);
                if (miso !== held) bad++;
            end
            sck = 1'b0;
        end
        repeat (ph) @(negedge clk);
        e3 = (ok && b1 == OP_ENABLE) ? int'(b2) : 0;
        e4 = (ok && en) ? model_read(b1, addr) : 0;
        chk({tag, " R4 byte1"}, int'(rx[31:24]), 0);
        chk({tag, " R4 byte2"}, int'(rx[23:16]), 0);
        chk({tag, " R10 byte3"}, int'(rx[15:8]), e3);
        chk({tag, " R8 byte4"}, int'(rx[7:0]), e4);
        chk({tag, " R9 high-phase glitches"}, bad, 0);
        if (ok) begin
            if (b1 == OP_ENABLE) begin
                en = 1'b1;
            end else if (en) begin
                if (b1 == OP_ERASE) begin
                    foreach (fm[k]) fm[k] = 8'hFF;
                    foreach (em[k]) em[k] = 8'hFF;
                    t_exec = cyc;
                end else if (b1 == OP_PWRITE) begin
                    if (addr < 512) fm[addr] = fm[addr] & int'(b4);
                    t_exec = cyc;
                end else if (b1 == OP_EWRITE) begin
                    if (addr < 64) em[addr] = int'(b4);
                    t_exec = cyc;
                end
            end
        end
    endtask

    task automatic send_partial(input logic [15:0] bits, input int nbits, input int ph);
        for (int i = 0; i < nbits; i++) begin
            mosi = bits[15-i];
            repeat (ph) @(negedge clk);
            sck = 1'b1;
            repeat (ph) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        foreach (fm[k]) fm[k] = 0;
        foreach (em[k]) em[k] = 0;
        idle(10);
        chk("R1 reset state miso", int'(miso), 0);
        prog_rst_n = 1'b0;
        idle(5);

        // R2: locked port ignores reads and writes
        send_frame(OP_EWRITE, 8'h00, 8'h03, 8'h77, 3, "R2 locked write");
        send_frame(OP_EREAD,  8'h00, 8'h03, 8'h00, 3, "R2 locked read");
        // R10: enable echo
        send_frame(OP_ENABLE, 8'h5A, 8'h00, 8'h00, 3, "R10 enable");
        // R5: chip erase
        send_frame(OP_ERASE, 8'h00, 8'h00, 8'h00, 3, "R5 erase");
        idle(GAP);
        send_frame(OP_PREAD, 8'h00, 8'h05, 8'h00, 3, "R5 flash low");
        send_frame(OP_PREAD, 8'h01, 8'hFF, 8'h00, 3, "R5 flash top");
        send_frame(OP_EREAD, 8'h00, 8'h3F, 8'h00, 3, "R5 ee top");
        // R6: EEPROM overwrite without erase
        send_frame(OP_EWRITE, 8'h00, 8'h03, 8'h3C, 3, "R6 ee first");
        idle(GAP);
        send_frame(OP_EWRITE, 8'h00, 8'h03, 8'hA5, 3, "R6 ee second");
        idle(GAP);
        send_frame(OP_EREAD, 8'h00, 8'h03, 8'h00, 3, "R6 ee readback");
        // R7: flash write ANDs
        send_frame(OP_PWRITE, 8'h00, 8'h05, 8'h3C, 3, "R7 flash first");
        idle(GAP);
        send_frame(OP_PWRITE, 8'h00, 8'h05, 8'hA5, 3, "R7 flash second");
        idle(GAP);
        send_frame(OP_PREAD, 8'h00, 8'h05, 8'h00, 3, "R7 flash readback");
        chk("R7 model flash AND value", fm[5], 8'h24);
        // R11: busy window
        send_frame(OP_EWRITE, 8'h00, 8'h07, 8'h11, 3, "R11 write");
        send_frame(OP_EWRITE, 8'h00, 8'h07, 8'h22, 3, "R11 write while busy");
        send_frame(OP_EREAD,  8'h00, 8'h07, 8'h00, 3, "R11 read while busy");
        idle(GAP);
        send_frame(OP_EREAD,  8'h00, 8'h07, 8'h00, 3, "R11 read after busy");
        chk("R11 model keeps first value", em[7], 8'h11);
        // R12: unknown opcode
        send_frame(8'h55, 8'h00, 8'h03, 8'h00, 3, "R12 unknown op");
        send_frame(OP_EREAD, 8'h00, 8'h03, 8'h00, 3, "R12 ee unchanged");
        // R13: out-of-range addresses
        send_frame(OP_EWRITE, 8'h00, 8'h43, 8'h00, 3, "R13 ee wrap write");
        idle(GAP);
        send_frame(OP_EREAD, 8'h00, 8'h03, 8'h00, 3, "R13 ee alias unchanged");
        send_frame(OP_PREAD, 8'h02, 8'h05, 8'h00, 3, "R13 flash beyond depth");
        // R3: slower clock range, four-cycle phases
        send_frame(OP_EWRITE, 8'h00, 8'h09, 8'h5B, 4, "R3 ph4 write");
        idle(GAP);
        send_frame(OP_EREAD, 8'h00, 8'h09, 8'h00, 4, "R3 ph4 read");
        send_frame(OP_ENABLE, 8'hC6, 8'h00, 8'h00, 4, "R3 ph4 echo");
        // R1: abort a partial instruction by releasing reset
        send_partial(16'h4E00, 12, 3);
        prog_rst_n = 1'b1;
        idle(6);
        chk("R1 miso after abort", int'(miso), 0);
        en = 1'b0;
        t_exec = -100000;
        prog_rst_n = 1'b0;
        idle(5);
        send_frame(OP_EWRITE, 8'h00, 8'h03, 8'h00, 3, "R1 relocked write");
        send_frame(OP_ENABLE, 8'h5A, 8'h00, 8'h00, 3, "R1 re-enable");
        send_frame(OP_EREAD,  8'h00, 8'h03, 8'h00, 3, "R1 realigned read");
        chk("R2 model ee[3] kept", em[3], 8'hA5);
        idle(5);
        finish_run();
    end

endmodule